// File: doc/BRIEF.md
# Coprocessor bus address decoder

This block sits between a coprocessor's 24-bit address bus and the memories and register file behind it. Each request is matched against a fixed set of address rules, checked in a fixed priority order: register I/O first, then cartridge ROM, the 8 KB banked RAM window, internal RAM, backup RAM and the packed-bitmap view. The result is a one-hot target select, the address already translated into the target's own space, a write strobe, and the number of clock ticks the access costs.

The 8 KB window at offsets 6000–7FFF of the low banks can be steered by a control bit. It points either at backup RAM or at the bitmap view, with a bank register choosing the 8 KB slice. Reads that hit no region report an open-bus flag and return the data value that was on the bus. Writes to ROM or to unmapped space raise no strobe. All outputs are registered, so a response appears one clock after its request. ROM bank mapping and bitmap packing are handled by neighbouring blocks.

Top module: `cbd_bus_decoder`

## Requirements
- R1: While reset is asserted, and right after it, every response output is zero.
- R2: An address with (addr & 0x40FE00) == 0x002200 selects I/O (select bit 0) with target address addr[8:0], and this check beats every other rule.
- R3: Offsets 8000–FFFF of banks 00–3F and 80–BF select ROM (select bit 1) with target address {addr[23], addr[21:16], addr[14:0]}, which places addr[23] at bit 21.
- R4: Banks C0–FF select ROM (select bit 1) across their whole 64 KB, passing the address through unchanged.
- R5: Offsets 0000–07FF and 3000–37FF of banks 00–3F and 80–BF select internal RAM (select bit 3) with target address addr[10:0].
- R6: Banks 40–4F select backup RAM (select bit 2) with the address masked to the backup RAM size (2^BWRAM_AW bytes).
- R7: Banks 60–6F select the bitmap view (select bit 4) with target address addr[19:0].
- R8: With the window control bit at 0, offsets 6000–7FFF of the low banks select backup RAM at (bank[4:0] × 0x2000 + addr[12:0]), masked to the backup RAM size.
- R9: With the window control bit at 1, the same window selects the bitmap view at (bank[6:0] × 0x2000 + addr[12:0]), wrapped to 20 bits.
- R10: The tick count is 4 for a window access or any address with (addr & 0xD00000) == 0x400000, and 2 for every other access.
- R11: A read that hits no region leaves the select at zero, raises the open-bus flag and returns the bus data input sampled with the request. The target address reads zero.
- R12: The write strobe is raised only for a write to I/O, internal RAM, backup RAM or bitmap. Writes to ROM or unmapped space raise no strobe.
- R13: A response appears exactly one clock after each request and carries at most one select bit. A cycle with no request yields an all-zero response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Coprocessor bus address |
| req_wdata | input | 8 | Write data |
| bus_mdr | input | 8 | Current data-bus value, returned on open-bus reads |
| win_to_bitmap | input | 1 | Window steering: 0 backup RAM, 1 bitmap view |
| win_bank | input | 7 | 8 KB slice selected for the window |
| rsp_valid | output | 1 | Response present |
| rsp_sel | output | 5 | One-hot target: 0 I/O, 1 ROM, 2 backup RAM, 3 internal RAM, 4 bitmap |
| rsp_addr | output | 24 | Translated target address |
| rsp_wr | output | 1 | Write strobe to the selected target |
| rsp_wdata | output | 8 | Write data forwarded on writes, else zero |
| rsp_ticks | output | 3 | Clock ticks the access costs |
| rsp_open_bus | output | 1 | Read hit no region |
| rsp_open_data | output | 8 | Bus value returned on an open-bus read, else zero |

## Verification
Each decision comes from the request registered one cycle earlier, so any wrong rule or wrong priority shows up on the very next response. It appears as a wrong select bit, a wrong translated address or a wrong tick count. A mis-steered window or an unmasked mirror changes rsp_addr or rsp_sel on the first window access, which makes both control-bit settings and a mirror-folding backup RAM size necessary stimuli. A strobe that leaks through on ROM writes, or open-bus data taken from the wrong cycle, is visible on that same response.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

   localparam int CBD_NUM_TGT   = 5;
   localparam int TGT_IO        = 0;
   localparam int TGT_ROM       = 1;
   localparam int TGT_BWRAM     = 2;
   localparam int TGT_IRAM      = 3;
   localparam int TGT_BITMAP    = 4;

   localparam int CBD_NUM_RULES = 8;

   typedef enum logic [2:0] {
      REG_NONE,
      REG_IO,
      REG_ROM_LO,
      REG_ROM_HI,
      REG_WIN,
      REG_IRAM,
      REG_BWRAM,
      REG_BITMAP
   } cbd_region_e;

   // Rule index is the priority: lower index wins.
   function automatic logic [23:0] rule_mask(int idx);
      case (idx)
         0:       return 24'h40FE00;
         1:       return 24'h408000;
         2:       return 24'hC00000;
         3:       return 24'h40E000;
         4, 5:    return 24'h40F800;
         default: return 24'hF00000;
      endcase
   endfunction

   function automatic logic [23:0] rule_value(int idx);
      case (idx)
         0:       return 24'h002200;
         1:       return 24'h008000;
         2:       return 24'hC00000;
         3:       return 24'h006000;
         4:       return 24'h000000;
         5:       return 24'h003000;
         6:       return 24'h400000;
         default: return 24'h600000;
      endcase
   endfunction

   function automatic cbd_region_e rule_region(int idx);
      case (idx)
         0:       return REG_IO;
         1:       return REG_ROM_LO;
         2:       return REG_ROM_HI;
         3:       return REG_WIN;
         4, 5:    return REG_IRAM;
         6:       return REG_BWRAM;
         default: return REG_BITMAP;
      endcase
   endfunction

endpackage

// File: rtl/cbd_region_match.sv
module cbd_region_match
   import cbd_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic [ADDR_W-1:0] addr,
   output cbd_region_e       region
);

   if (ADDR_W != 24) begin : g_bad_addr_w
      $error("cbd_region_match: rules are defined for a 24-bit address");
   end

   logic [CBD_NUM_RULES-1:0] hit;

   for (genvar g = 0; g < CBD_NUM_RULES; g++) begin : g_rule
      localparam logic [23:0] MASK  = rule_mask(g);
      localparam logic [23:0] VALUE = rule_value(g);
      assign hit[g] = ((addr & MASK) == VALUE);
   end

   // Walk from lowest priority to highest so the highest-priority hit remains.
   always_comb begin
      region = REG_NONE;
      for (int i = CBD_NUM_RULES - 1; i >= 0; i--) begin
         if (hit[i]) region = rule_region(i);
      end
   end

endmodule

// File: rtl/cbd_addr_xlate.sv
module cbd_addr_xlate
   import cbd_pkg::*;
#(
   parameter int ADDR_W        = 24,
   parameter int IO_AW         = 9,
   parameter int IRAM_AW       = 11,
   parameter int BWRAM_AW      = 18,
   parameter int BITMAP_AW     = 20,
   parameter int WIN_AW        = 13,
   parameter int WIN_BW_BANK_W = 5,
   parameter int BANK_W        = 7
) (
   input  logic [ADDR_W-1:0]      addr,
   input  cbd_region_e            region,
   input  logic                   win_to_bitmap,
   input  logic [BANK_W-1:0]      win_bank,
   output logic [CBD_NUM_TGT-1:0] sel,
   output logic [ADDR_W-1:0]      tgt_addr,
   output logic                   mapped,
   output logic                   writable
);

   localparam int WIN_BW_W = WIN_BW_BANK_W + WIN_AW;
   localparam int WIN_BM_W = BANK_W + WIN_AW;
   localparam int ROM_LO_W = 1 + 6 + 15;
   localparam logic [ADDR_W-1:0] BW_MASK = ADDR_W'((64'd1 << BWRAM_AW) - 64'd1);
   localparam logic [ADDR_W-1:0] BM_MASK = ADDR_W'((64'd1 << BITMAP_AW) - 64'd1);

   if (BWRAM_AW < 1 || BWRAM_AW > BITMAP_AW) begin : g_bad_bw
      $error("cbd_addr_xlate: BWRAM_AW must lie between 1 and BITMAP_AW");
   end
   if (WIN_BW_BANK_W > BANK_W) begin : g_bad_bank
      $error("cbd_addr_xlate: window bank slice wider than bank register");
   end
   if (IO_AW > ADDR_W || IRAM_AW > ADDR_W || WIN_BM_W > ADDR_W) begin : g_bad_w
      $error("cbd_addr_xlate: sub-address wider than the bus");
   end

   logic [ADDR_W-1:0] win_bw_raw;
   logic [ADDR_W-1:0] win_bm_raw;
   logic [ADDR_W-1:0] win_bw_addr;
   logic [ADDR_W-1:0] win_bm_addr;
   logic [ADDR_W-1:0] bw_direct;
   logic [ADDR_W-1:0] rom_lo_addr;

   assign win_bw_raw  = ADDR_W'({win_bank[WIN_BW_BANK_W-1:0], addr[WIN_AW-1:0]});
   assign win_bm_raw  = ADDR_W'({win_bank, addr[WIN_AW-1:0]});
   assign rom_lo_addr = ADDR_W'({addr[23], addr[21:16], addr[14:0]});

   // Mirror folding is only needed when the RAM is smaller than the span reaching it.
   if (BWRAM_AW < WIN_BW_W) begin : g_win_bw_fold
      assign win_bw_addr = win_bw_raw & BW_MASK;
   end else begin : g_win_bw_full
      assign win_bw_addr = win_bw_raw;
   end

   if (BITMAP_AW < WIN_BM_W) begin : g_win_bm_fold
      assign win_bm_addr = win_bm_raw & BM_MASK;
   end else begin : g_win_bm_full
      assign win_bm_addr = win_bm_raw;
   end

   assign bw_direct = addr & BW_MASK;

   always_comb begin
      sel      = '0;
      tgt_addr = '0;
      mapped   = 1'b1;
      writable = 1'b1;
      case (region)
         REG_IO: begin
            sel[TGT_IO] = 1'b1;
            tgt_addr    = ADDR_W'(addr[IO_AW-1:0]);
         end
         REG_ROM_LO: begin
            sel[TGT_ROM] = 1'b1;
            tgt_addr     = rom_lo_addr;
            writable     = 1'b0;
         end
         REG_ROM_HI: begin
            sel[TGT_ROM] = 1'b1;
            tgt_addr     = addr;
            writable     = 1'b0;
         end
         REG_WIN: begin
            if (win_to_bitmap) begin
               sel[TGT_BITMAP] = 1'b1;
               tgt_addr        = win_bm_addr;
            end else begin
               sel[TGT_BWRAM] = 1'b1;
               tgt_addr       = win_bw_addr;
            end
         end
         REG_IRAM: begin
            sel[TGT_IRAM] = 1'b1;
            tgt_addr      = ADDR_W'(addr[IRAM_AW-1:0]);
         end
         REG_BWRAM: begin
            sel[TGT_BWRAM] = 1'b1;
            tgt_addr       = bw_direct;
         end
         REG_BITMAP: begin
            sel[TGT_BITMAP] = 1'b1;
            tgt_addr        = addr & BM_MASK;
         end
         default: begin
            mapped   = 1'b0;
            writable = 1'b0;
         end
      endcase
   end

   if (ROM_LO_W > ADDR_W) begin : g_bad_rom
      $error("cbd_addr_xlate: ROM translation wider than the bus");
   end

endmodule

// File: rtl/cbd_wait_gen.sv
module cbd_wait_gen
   import cbd_pkg::*;
#(
   parameter int              ADDR_W     = 24,
   parameter int              TICK_W     = 3,
   parameter int              FAST_TICKS = 2,
   parameter int              SLOW_TICKS = 4,
   parameter logic [23:0]     SLOW_MASK  = 24'hD00000,
   parameter logic [23:0]     SLOW_VALUE = 24'h400000
) (
   input  logic [ADDR_W-1:0] addr,
   input  cbd_region_e       region,
   output logic [TICK_W-1:0] ticks
);

   localparam int TICK_MAX = (1 << TICK_W) - 1;

   if (SLOW_TICKS > TICK_MAX || FAST_TICKS > TICK_MAX) begin : g_bad_ticks
      $error("cbd_wait_gen: tick count does not fit TICK_W");
   end
   if (FAST_TICKS < 1 || SLOW_TICKS < FAST_TICKS) begin : g_bad_order
      $error("cbd_wait_gen: slow accesses must not be faster than fast ones");
   end

   logic slow;

   assign slow  = (region == REG_WIN) || ((addr & SLOW_MASK) == SLOW_VALUE);
   assign ticks = slow ? TICK_W'(SLOW_TICKS) : TICK_W'(FAST_TICKS);

endmodule

// File: rtl/cbd_rsp_stage.sv
module cbd_rsp_stage
   import cbd_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 8,
   parameter int TICK_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [DATA_W-1:0]      req_wdata,
   input  logic [DATA_W-1:0]      bus_mdr,
   input  logic [CBD_NUM_TGT-1:0] sel,
   input  logic [ADDR_W-1:0]      tgt_addr,
   input  logic                   mapped,
   input  logic                   writable,
   input  logic [TICK_W-1:0]      ticks,
   output logic                   rsp_valid,
   output logic [CBD_NUM_TGT-1:0] rsp_sel,
   output logic [ADDR_W-1:0]      rsp_addr,
   output logic                   rsp_wr,
   output logic [DATA_W-1:0]      rsp_wdata,
   output logic [TICK_W-1:0]      rsp_ticks,
   output logic                   rsp_open_bus,
   output logic [DATA_W-1:0]      rsp_open_data
);

   logic open_rd;
   assign open_rd = req_valid && !req_write && !mapped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_sel       <= '0;
         rsp_addr      <= '0;
         rsp_wr        <= 1'b0;
         rsp_wdata     <= '0;
         rsp_ticks     <= '0;
         rsp_open_bus  <= 1'b0;
         rsp_open_data <= '0;
      end else begin
         rsp_valid     <= req_valid;
         rsp_sel       <= req_valid ? sel : '0;
         rsp_addr      <= req_valid ? tgt_addr : '0;
         rsp_wr        <= req_valid && req_write && writable;
         rsp_wdata     <= (req_valid && req_write) ? req_wdata : '0;
         rsp_ticks     <= req_valid ? ticks : '0;
         rsp_open_bus  <= open_rd;
         rsp_open_data <= open_rd ? bus_mdr : '0;
      end
   end

endmodule

// File: rtl/cbd_bus_decoder.sv
module cbd_bus_decoder
   import cbd_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 8,
   parameter int BANK_W    = 7,
   parameter int BWRAM_AW  = 18,
   parameter int TICK_W    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   input  logic [DATA_W-1:0]      bus_mdr,
   input  logic                   win_to_bitmap,
   input  logic [BANK_W-1:0]      win_bank,
   output logic                   rsp_valid,
   output logic [CBD_NUM_TGT-1:0] rsp_sel,
   output logic [ADDR_W-1:0]      rsp_addr,
   output logic                   rsp_wr,
   output logic [DATA_W-1:0]      rsp_wdata,
   output logic [TICK_W-1:0]      rsp_ticks,
   output logic                   rsp_open_bus,
   output logic [DATA_W-1:0]      rsp_open_data
);

   if (DATA_W < 1) begin : g_bad_data
      $error("cbd_bus_decoder: DATA_W must be positive");
   end

   cbd_region_e            region;
   logic [CBD_NUM_TGT-1:0] sel;
   logic [ADDR_W-1:0]      tgt_addr;
   logic                   mapped;
   logic                   writable;
   logic [TICK_W-1:0]      ticks;

   cbd_region_match #(.ADDR_W(ADDR_W)) u_match (
      .addr   (req_addr),
      .region (region)
   );

   cbd_addr_xlate #(
      .ADDR_W   (ADDR_W),
      .BWRAM_AW (BWRAM_AW),
      .BANK_W   (BANK_W)
   ) u_xlate (
      .addr          (req_addr),
      .region        (region),
      .win_to_bitmap (win_to_bitmap),
      .win_bank      (win_bank),
      .sel           (sel),
      .tgt_addr      (tgt_addr),
      .mapped        (mapped),
      .writable      (writable)
   );

   cbd_wait_gen #(
      .ADDR_W (ADDR_W),
      .TICK_W (TICK_W)
   ) u_wait (
      .addr   (req_addr),
      .region (region),
      .ticks  (ticks)
   );

   cbd_rsp_stage #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .TICK_W (TICK_W)
   ) u_rsp (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_wdata     (req_wdata),
      .bus_mdr       (bus_mdr),
      .sel           (sel),
      .tgt_addr      (tgt_addr),
      .mapped        (mapped),
      .writable      (writable),
      .ticks         (ticks),
      .rsp_valid     (rsp_valid),
      .rsp_sel       (rsp_sel),
      .rsp_addr      (rsp_addr),
      .rsp_wr        (rsp_wr),
      .rsp_wdata     (rsp_wdata),
      .rsp_ticks     (rsp_ticks),
      .rsp_open_bus  (rsp_open_bus),
      .rsp_open_data (rsp_open_data)
   );

endmodule

// File: rtl/cbd_bus_decoder_chk.sv
module cbd_bus_decoder_chk
   import cbd_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 8,
   parameter int TICK_W = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_write,
   input logic [ADDR_W-1:0]      req_addr,
   input logic [DATA_W-1:0]      bus_mdr,
   input logic                   win_to_bitmap,
   input logic                   rsp_valid,
   input logic [CBD_NUM_TGT-1:0] rsp_sel,
   input logic                   rsp_wr,
   input logic [TICK_W-1:0]      rsp_ticks,
   input logic                   rsp_open_bus,
   input logic [DATA_W-1:0]      rsp_open_data
);

   logic in_window;
   assign in_window = req_valid && ((req_addr & 24'h40E000) == 24'h006000);

   assert_sel_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_sel));

   assert_rsp_follows_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_idle_is_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && rsp_sel == '0 && !rsp_wr && !rsp_open_bus));

   assert_no_rom_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_sel[TGT_ROM] |-> !rsp_wr);

   assert_open_bus_unselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_open_bus |-> (rsp_sel == '0 && !rsp_wr));

   assert_open_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> (!rsp_open_bus || rsp_open_data == $past(bus_mdr)));

   assert_window_slow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_window |=> (rsp_ticks == TICK_W'(4)));

   assert_tick_values_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_ticks == TICK_W'(2) || rsp_ticks == TICK_W'(4)));

   assert_window_bwram_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_window && !win_to_bitmap) |=> $onehot(rsp_sel) && rsp_sel[TGT_BWRAM]);

   assert_window_bitmap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_window && win_to_bitmap) |=> $onehot(rsp_sel) && rsp_sel[TGT_BITMAP]);

endmodule

bind cbd_bus_decoder cbd_bus_decoder_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .TICK_W (TICK_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_write     (req_write),
   .req_addr      (req_addr),
   .bus_mdr       (bus_mdr),
   .win_to_bitmap (win_to_bitmap),
   .rsp_valid     (rsp_valid),
   .rsp_sel       (rsp_sel),
   .rsp_wr        (rsp_wr),
   .rsp_ticks     (rsp_ticks),
   .rsp_open_bus  (rsp_open_bus),
   .rsp_open_data (rsp_open_data)
);

// File: tb/cbd_bus_decoder_tb.sv
`timescale 1ns/1ps
module cbd_bus_decoder_tb;

   localparam int BW_AW  = 16;
   localparam int RSP_W  = 51;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [23:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic [7:0]  bus_mdr = '0;
   logic        win_to_bitmap = 1'b0;
   logic [6:0]  win_bank = '0;

   logic        rsp_valid;
   logic [4:0]  rsp_sel;
   logic [23:0] rsp_addr;
   logic        rsp_wr;
   logic [7:0]  rsp_wdata;
   logic [2:0]  rsp_ticks;
   logic        rsp_open_bus;
   logic [7:0]  rsp_open_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [RSP_W-1:0] exp_q[$];

   always #4 clk = ~clk;

   cbd_bus_decoder #(.BWRAM_AW(BW_AW)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_addr      (req_addr),
      .req_wdata     (req_wdata),
      .bus_mdr       (bus_mdr),
      .win_to_bitmap (win_to_bitmap),
      .win_bank      (win_bank),
      .rsp_valid     (rsp_valid),
      .rsp_sel       (rsp_sel),
      .rsp_addr      (rsp_addr),
      .rsp_wr        (rsp_wr),
      .rsp_wdata     (rsp_wdata),
      .rsp_ticks     (rsp_ticks),
      .rsp_open_bus  (rsp_open_bus),
      .rsp_open_data (rsp_open_data)
   );

   function automatic logic [RSP_W-1:0] model(input bit v, input bit wr, input int a,
                                               input int wd, input int mdr,
                                               input bit tob, input int bank);
      int sel = 0;
      int ta  = 0;
      int tk;
      bit win = 0;
      bit strobe, open;
      int od;
      if (!v) return '0;
      if ((a & 'h40FE00) == 'h002200) begin
         sel = 1; ta = a & 'h1FF;
      end else if ((a & 'h408000) == 'h008000) begin
         sel = 2; ta = ((a & 'h800000) >> 2) | ((a & 'h3F0000) >> 1) | (a & 'h7FFF);
      end else if ((a & 'hC00000) == 'hC00000) begin
         sel = 2; ta = a;
      end else if ((a & 'h40E000) == 'h006000) begin
         win = 1;
         if (!tob) begin
            sel = 4; ta = ((bank % 32) * 'h2000 + (a & 'h1FFF)) % (1 << BW_AW);
         end else begin
            sel = 16; ta = (bank * 'h2000 + (a & 'h1FFF)) % 'h100000;
         end
      end else if ((a & 'h40F800) == 0 || (a & 'h40F800) == 'h3000) begin
         sel = 8; ta = a % 2048;
      end else if ((a & 'hF00000) == 'h400000) begin
         sel = 4; ta = a % (1 << BW_AW);
      end else if ((a & 'hF00000) == 'h600000) begin
         sel = 16; ta = a & 'hFFFFF;
      end
      tk     = (win || (a & 'hD00000) == 'h400000) ? 4 : 2;
      strobe = wr && sel != 0 && sel != 2;
      open   = !wr && sel == 0;
      od     = open ? mdr : 0;
      return {1'b1, sel[4:0], ta[23:0], strobe, (wr ? wd[7:0] : 8'h00), tk[2:0], open, od[7:0]};
   endfunction

   function automatic logic [RSP_W-1:0] observed();
      return {rsp_valid, rsp_sel, rsp_addr, rsp_wr, rsp_wdata, rsp_ticks,
              rsp_open_bus, rsp_open_data};
   endfunction

   task automatic compare(input string tag);
      logic [RSP_W-1:0] exp;
      exp = exp_q.pop_front();
      checks++;
      if (observed() !== exp) begin
         errors++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, req_addr, observed(), exp);
      end
   endtask

   task automatic access(input string tag, input bit v, input bit wr, input int a,
                         input int wd, input int mdr, input bit tob, input int bank);
      @(negedge clk);
      req_valid     = v;
      req_write     = wr;
      req_addr      = a[23:0];
      req_wdata     = wd[7:0];
      bus_mdr       = mdr[7:0];
      win_to_bitmap = tob;
      win_bank      = bank[6:0];
      exp_q.push_back(model(v, wr, a, wd, mdr, tob, bank));
      @(posedge clk);
      #2;
      compare(tag);
   endtask

   task automatic rd(input string tag, input int a);
      access(tag, 1'b1, 1'b0, a, 0, 'h5A, 1'b0, 0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      // R1: reset holds every output at zero
      repeat (3) @(posedge clk);
      #2;
      exp_q.push_back('0);
      compare("R1 during reset");
      @(negedge clk);
      rst_n = 1'b1;
      access("R1 first idle after reset", 1'b0, 1'b0, 0, 0, 0, 1'b0, 0);

      // R2: I/O space, and its priority
      rd("R2 io low", 'h002200);
      rd("R2 io high mirror", 'h8023FF);
      access("R2 io write", 1'b1, 1'b1, 'h3F2301, 'h77, 0, 1'b0, 0);
      rd("R6 bank 40 offset 2200 is not io", 'h402200);

      // R3 / R4: ROM
      rd("R3 rom low first", 'h008000);
      rd("R3 rom translate top", 'hBFFFFF);
      rd("R3 rom translate mid", 'h129ABC);
      rd("R4 rom high", 'hC01234);
      rd("R4 rom high top", 'hFFFFFF);
      access("R12 rom write suppressed", 1'b1, 1'b1, 'h008000, 'hEE, 0, 1'b0, 0);
      access("R12 rom high write suppressed", 1'b1, 1'b1, 'hD00010, 'hEE, 0, 1'b0, 0);

      // R5: internal RAM mirrors
      rd("R5 iram top", 'h0007FF);
      rd("R5 iram mirror", 'h003456);
      rd("R5 iram high bank", 'h803000);
      access("R5 iram write", 1'b1, 1'b1, 'h9F37FF, 'h12, 0, 1'b0, 0);

      // R6 / R7: direct backup RAM and bitmap banks
      rd("R6 bwram masked", 'h412345);
      rd("R6 bwram top", 'h4FFFFF);
      access("R7 bitmap write", 1'b1, 1'b1, 'h6ABCDE, 'h03, 0, 1'b0, 0);
      rd("R7 bitmap top", 'h6FFFFF);

      // R8 / R9 / R10: window steering, slice selection and slow ticks
      access("R8 window bwram fold", 1'b1, 1'b0, 'h007ABC, 0, 0, 1'b0, 'h1F);
      access("R8 window bank upper bits dropped", 1'b1, 1'b0, 'h006000, 0, 0, 1'b0, 'h65);
      access("R9 window bitmap top", 1'b1, 1'b0, 'h806001, 0, 0, 1'b1, 'h7F);
      access("R9 window bitmap write", 1'b1, 1'b1, 'h3F7FFF, 'h02, 0, 1'b1, 'h41);
      rd("R10 fast rom ticks", 'hC00000);

      // R11 / R12: unmapped space
      access("R11 open bus bank 50", 1'b1, 1'b0, 'h500000, 0, 'hA5, 1'b0, 0);
      access("R11 open bus gap", 1'b1, 1'b0, 'h001000, 0, 'h3C, 1'b0, 0);
      access("R11 open bus bank 7F", 1'b1, 1'b0, 'h7F0000, 0, 'hFF, 1'b0, 0);
      access("R11 just past iram", 1'b1, 1'b0, 'h000800, 0, 'h81, 1'b0, 0);
      access("R12 unmapped write ignored", 1'b1, 1'b1, 'h5F1234, 'h99, 'h44, 1'b0, 0);

      // R13: idle between requests, then sweep every bank and region
      access("R13 idle gap", 1'b0, 1'b1, 'h002200, 'h11, 'h22, 1'b0, 0);
      for (int b = 0; b < 256; b++) begin
         for (int k = 0; k < 7; k++) begin
            int offs;
            case (k)
               0: offs = 'h0000;
               1: offs = 'h0400;
               2: offs = 'h2200;
               3: offs = 'h3100;
               4: offs = 'h6100;
               5: offs = 'h9000;
               default: offs = 'h2600;
            endcase
            access("R13 sweep", 1'b1, k[0], (b << 16) | offs, b, 255 - b, b[1], b);
         end
      end
      access("R13 final idle", 1'b0, 1'b0, 0, 0, 0, 1'b0, 0);
      summary();
   end

endmodule